// File: doc/BRIEF.md
# DRAM Refresh and Power-Up Sequencer

This block keeps an asynchronous DRAM refreshed by issuing refresh cycles in which the column strobe is lowered before the row strobe. The memory's own internal row counter picks the row, so the block drives no address, no write enable and no output enable. It shares the strobe pins with an access controller. For each refresh it raises a bus request and waits for the grant. It then drives one complete strobe sequence, including precharge, and only then drops the request.

After reset the block first waits out a settling period with the bus left alone. It then runs a fixed burst of initialisation refreshes. Only after that burst does it raise a ready flag, which tells the access controller that normal accesses may begin. From then on an interval timer adds one refresh to a debt counter on every tick. While the debt is non-zero the block keeps asking for the bus. Refreshes that a long page access holds off therefore build up, up to a ceiling, and are issued back to back once the bus is granted.

All timings are parameters counted in clock cycles. The defaults suit a 100 MHz clock: a 200 µs settle, eight initialisation refreshes, one refresh every 15.6 µs, a debt ceiling of eight, and strobe widths that meet a 60 ns speed grade.

Top module: `dram_refresh_sequencer`

## Requirements
- R1: While reset is applied and on the first cycle after it, ras_n and cas_n are high (inactive), bus_req is low and ready is low.
- R2: bus_req stays low for the first SETTLE_CYC clock cycles after reset is released. It first rises SETTLE_CYC+1 cycles after release.
- R3: Once a grant has been sampled, a refresh cycle drives cas_n low for CSR_CYC cycles with ras_n high. It then drives ras_n low for RAS_CYC cycles, with cas_n held low for the first CHR_CYC of them. Last come RP_CYC cycles with both strobes high. bus_req stays high through the whole sequence and drops in the cycle after it.
- R4: While idle with a refresh owed, the block raises bus_req on the next cycle and holds it until bus_gnt is sampled high. Neither strobe moves before that.
- R5: Exactly INIT_REFRESHES refresh cycles (falling edges of ras_n) occur before ready rises.
- R6: ready rises on the cycle after the last initialisation refresh completes. It stays high until reset is applied again.
- R7: After ready, one refresh is added to the debt every INTERVAL_CYC cycles. With the grant given promptly, the long-run rate is one refresh per interval.
- R8: The debt saturates at DEBT_MAX. While the grant is withheld, bus_req stays high. Once grants resume, at most DEBT_MAX refreshes, plus those from ticks that arrive in the meantime, are issued back to back.
- R9: Each completed refresh removes one from the debt. A tick and a completion in the same cycle leave the debt unchanged. Once the backlog is drained, the rate returns to one refresh per interval.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_gnt | input | 1 | Strobe bus granted by the access controller; sampled while requesting |
| bus_req | output | 1 | Request for, and ownership of, the strobe bus |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe for both byte lanes, active low |
| ready | output | 1 | Initialisation complete; normal accesses may start |

## Verification
The sequencer is run through its settle and burst phases with the grant returned at once. Counting row-strobe edges before ready separates a correct burst length from an off-by-one. Steady refresh is then tried twice, with an immediate grant and with a three-cycle grant delay, which shows that strobe timing does not depend on how long arbitration takes. Finally the grant is withheld for fifteen intervals and then restored. The catch-up count tells a saturating debt apart from an unbounded one, and the rate afterwards shows that completions really pay the debt down.

// File: rtl/dram_refresh_pkg.sv
// Package: shared state encodings for the refresh sequencer.
// Assumes: nothing beyond IEEE 1800-2017.
package dram_refresh_pkg;

    // Stages of one refresh strobe sequence on the shared bus.
    typedef enum logic [2:0] {
        OP_IDLE = 3'd0,
        OP_REQ  = 3'd1,
        OP_CSR  = 3'd2,
        OP_ACT  = 3'd3,
        OP_PRE  = 3'd4
    } op_e;

    // Life phases of the memory after reset.
    typedef enum logic [1:0] {
        PH_SETTLE = 2'd0,
        PH_BURST  = 2'd1,
        PH_RUN    = 2'd2
    } phase_e;

endpackage

// File: rtl/refresh_interval_timer.sv
// Module: refresh_interval_timer
// Emits a one-cycle tick every INTERVAL_CYC cycles while enabled.
// Assumes: INTERVAL_CYC >= 2; the count restarts from zero when en drops.
module refresh_interval_timer #(
    parameter int INTERVAL_CYC = 1560
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    output logic tick
);
    localparam int CW = $clog2(INTERVAL_CYC);
    localparam logic [CW-1:0] LAST = CW'(INTERVAL_CYC - 1);

    logic [CW-1:0] cnt;

    // Free-running interval count, held at zero while disabled.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            cnt <= '0;
        end else if (cnt == LAST) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    // Tick on the final count of each interval.
    always_comb begin
        tick = en && (cnt == LAST);
    end

    // R7: ticks are isolated single-cycle pulses.
    p_tick_isolated_r7: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);

endmodule

// File: rtl/refresh_debt_counter.sv
// Module: refresh_debt_counter
// Counts refreshes owed: +1 per tick, -1 per completed refresh, ceiling DEBT_MAX.
// Assumes: done never arrives while the count is zero (the sequencer only
// starts a refresh when something is owed).
module refresh_debt_counter #(
    parameter int DEBT_MAX = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic done,
    output logic owed
);
    localparam int DW = $clog2(DEBT_MAX + 1);
    localparam logic [DW-1:0] CAP = DW'(DEBT_MAX);

    logic [DW-1:0] level;

    // Saturating up/down count of deferred refreshes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            level <= '0;
        end else if (tick && !done) begin
            if (level != CAP) begin
                level <= level + 1'b1;
            end
        end else if (done && !tick) begin
            if (level != '0) begin
                level <= level - 1'b1;
            end
        end
    end

    // A refresh is owed whenever the count is non-zero.
    always_comb begin
        owed = (level != '0);
    end

    // R8: the count never exceeds its ceiling.
    p_debt_cap_r8: assert property (@(posedge clk) disable iff (!rst_n)
        level <= CAP);

    // R9: the count moves by at most one per cycle.
    p_debt_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (level == $past(level)) || (level == $past(level) + 1'b1) ||
        (level + 1'b1 == $past(level)));

    // R9: a completion with no tick is never lost.
    p_debt_pays_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !tick && owed) |=> (level + 1'b1 == $past(level)));

endmodule

// File: rtl/refresh_strobe_fsm.sv
// Module: refresh_strobe_fsm
// Requests the strobe bus and, once granted, plays one column-first refresh
// cycle: CAS low, then RAS low (CAS released after CHR_CYC), then precharge.
// Assumes: bus_gnt stays high from grant until bus_req drops; CHR_CYC <= RAS_CYC.
// Strobes are decoded from state flops; a pad flop downstream is expected.
module refresh_strobe_fsm
    import dram_refresh_pkg::*;
#(
    parameter int CSR_CYC = 1,
    parameter int CHR_CYC = 2,
    parameter int RAS_CYC = 6,
    parameter int RP_CYC  = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic need,
    input  logic bus_gnt,
    output logic bus_req,
    output logic ras_n,
    output logic cas_n,
    output logic done
);
    localparam int MAXC   = (CSR_CYC > RAS_CYC) ? ((CSR_CYC > RP_CYC) ? CSR_CYC : RP_CYC)
                                                : ((RAS_CYC > RP_CYC) ? RAS_CYC : RP_CYC);
    localparam int SW     = $clog2(MAXC + 1);
    localparam logic [SW-1:0] CSR_LAST = SW'(CSR_CYC - 1);
    localparam logic [SW-1:0] RAS_LAST = SW'(RAS_CYC - 1);
    localparam logic [SW-1:0] RP_LAST  = SW'(RP_CYC - 1);
    localparam logic [SW-1:0] CHR_LEN  = SW'(CHR_CYC);

    op_e          state;
    logic [SW-1:0] step;

    // Sequence stage and cycle-within-stage counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= OP_IDLE;
            step  <= '0;
        end else begin
            case (state)
                OP_IDLE: begin
                    if (need) state <= OP_REQ;
                    step <= '0;
                end
                OP_REQ: begin
                    if (bus_gnt) state <= OP_CSR;
                    step <= '0;
                end
                OP_CSR: begin
                    if (step == CSR_LAST) begin
                        state <= OP_ACT;
                        step  <= '0;
                    end else begin
                        step <= step + 1'b1;
                    end
                end
                OP_ACT: begin
                    if (step == RAS_LAST) begin
                        state <= OP_PRE;
                        step  <= '0;
                    end else begin
                        step <= step + 1'b1;
                    end
                end
                OP_PRE: begin
                    if (step == RP_LAST) begin
                        state <= OP_IDLE;
                        step  <= '0;
                    end else begin
                        step <= step + 1'b1;
                    end
                end
                default: begin
                    state <= OP_IDLE;
                    step  <= '0;
                end
            endcase
        end
    end

    // Strobe, request and completion decode from the stage.
    always_comb begin
        bus_req = (state != OP_IDLE);
        ras_n   = (state != OP_ACT);
        cas_n   = !((state == OP_CSR) || ((state == OP_ACT) && (step < CHR_LEN)));
        done    = (state == OP_PRE) && (step == RP_LAST);
    end

    // R3: the column strobe is already low, and was low a cycle earlier, when RAS falls.
    p_cas_leads_ras_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ras_n) |-> (!cas_n && $past(!cas_n)));

    // R3: RAS never rises while CAS is still low.
    p_cas_off_at_ras_rise_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ras_n) |-> cas_n);

    // R4: strobes move only while the bus is owned.
    p_strobes_owned_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!ras_n || !cas_n) |-> bus_req);

    // R4: an ungranted request is held.
    p_req_held_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == OP_REQ && !bus_gnt) |=> (state == OP_REQ));

endmodule

// File: rtl/dram_refresh_sequencer.sv
// Module: dram_refresh_sequencer (top)
// Settle wait, then an initialisation refresh burst, then periodic refresh
// with a saturating debt of deferred cycles. All timings in clock cycles.
// Assumes: the access controller grants the bus only while bus_req is high
// and keeps the grant until bus_req drops.
module dram_refresh_sequencer
    import dram_refresh_pkg::*;
#(
    parameter int SETTLE_CYC     = 20000,
    parameter int INIT_REFRESHES = 8,
    parameter int INTERVAL_CYC   = 1560,
    parameter int DEBT_MAX       = 8,
    parameter int CSR_CYC        = 1,
    parameter int CHR_CYC        = 2,
    parameter int RAS_CYC        = 6,
    parameter int RP_CYC         = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bus_gnt,
    output logic bus_req,
    output logic ras_n,
    output logic cas_n,
    output logic ready
);
    localparam int SCW = $clog2(SETTLE_CYC);
    localparam int BCW = $clog2(INIT_REFRESHES + 1);
    localparam logic [SCW-1:0] SETTLE_LAST = SCW'(SETTLE_CYC - 1);
    localparam logic [BCW-1:0] BURST_LEN   = BCW'(INIT_REFRESHES);

    phase_e         phase;
    logic [SCW-1:0] settle_cnt;
    logic [BCW-1:0] burst_left;
    logic           need;
    logic           done;
    logic           tick;
    logic           owed;
    logic           run_done;

    // Phase progression: settle, burst of init refreshes, then run.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase      <= PH_SETTLE;
            settle_cnt <= '0;
            burst_left <= BURST_LEN;
        end else begin
            case (phase)
                PH_SETTLE: begin
                    if (settle_cnt == SETTLE_LAST) phase <= PH_BURST;
                    else settle_cnt <= settle_cnt + 1'b1;
                end
                PH_BURST: begin
                    if (done) begin
                        burst_left <= burst_left - 1'b1;
                        if (burst_left == BCW'(1)) phase <= PH_RUN;
                    end
                end
                default: phase <= PH_RUN;
            endcase
        end
    end

    // Refresh demand for the strobe sequencer and the run-phase completion.
    always_comb begin
        need     = ((phase == PH_BURST) && (burst_left != '0)) || ((phase == PH_RUN) && owed);
        run_done = done && (phase == PH_RUN);
        ready    = (phase == PH_RUN);
    end

    refresh_interval_timer #(
        .INTERVAL_CYC (INTERVAL_CYC)
    ) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (ready),
        .tick  (tick)
    );

    refresh_debt_counter #(
        .DEBT_MAX (DEBT_MAX)
    ) u_debt (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick),
        .done  (run_done),
        .owed  (owed)
    );

    refresh_strobe_fsm #(
        .CSR_CYC (CSR_CYC),
        .CHR_CYC (CHR_CYC),
        .RAS_CYC (RAS_CYC),
        .RP_CYC  (RP_CYC)
    ) u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .need    (need),
        .bus_gnt (bus_gnt),
        .bus_req (bus_req),
        .ras_n   (ras_n),
        .cas_n   (cas_n),
        .done    (done)
    );

    // R2: the bus is left alone during the settle wait.
    p_quiet_settle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_SETTLE) |-> !bus_req);

    // R6: ready never falls outside reset.
    p_ready_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ready |=> ready);

    // R5: ready rises only right after a completed refresh.
    p_ready_after_refresh_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ready) |-> $past(done));

    // R8: owed refresh keeps the request alive.
    p_req_while_owed_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && owed && !bus_req) |=> bus_req);

endmodule

// File: tb/dram_refresh_sequencer_tb.sv
module dram_refresh_sequencer_tb;
    localparam int CLK_P    = 10;
    localparam int SETTLE   = 20;
    localparam int BURST    = 8;
    localparam int INTERVAL = 120;
    localparam int DMAX     = 8;
    localparam int CSR      = 2;
    localparam int CHR      = 2;
    localparam int RAS      = 4;
    localparam int RP       = 3;
    localparam int RST_CYC  = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bus_gnt = 1'b0;
    logic bus_req, ras_n, cas_n, ready;

    int checks = 0;
    int fails  = 0;
    bit summary_done = 0;

    // scenario controls, written only at posedges
    bit gnt_en = 1'b1;
    int gnt_delay = 0;

    // measurements, written only at negedges
    int cyc = 0;
    int first_req = -1;
    int falls_pre_ready = 0;
    int falls = 0;
    bit ready_seen = 0;
    bit prev_ras = 1'b1;
    int wait_cnt = 0;

    // reference model state
    int m_phase, m_settle, m_burst, m_debt, m_tmr, m_op, m_step;

    always #(CLK_P/2) clk = ~clk;

    dram_refresh_sequencer #(
        .SETTLE_CYC (SETTLE), .INIT_REFRESHES (BURST), .INTERVAL_CYC (INTERVAL),
        .DEBT_MAX (DMAX), .CSR_CYC (CSR), .CHR_CYC (CHR), .RAS_CYC (RAS), .RP_CYC (RP)
    ) u_dut (
        .clk (clk), .rst_n (rst_n), .bus_gnt (bus_gnt),
        .bus_req (bus_req), .ras_n (ras_n), .cas_n (cas_n), .ready (ready)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    task automatic model_reset();
        m_phase = 0; m_settle = 0; m_burst = BURST; m_debt = 0;
        m_tmr = 0; m_op = 0; m_step = 0;
    endtask

    task automatic model_step(input bit g);
        bit done_v, tick_v, need_v;
        int ph;
        ph     = m_phase;
        done_v = (m_op == 4) && (m_step == RP - 1);
        tick_v = (ph == 2) && (m_tmr == INTERVAL - 1);
        need_v = ((ph == 1) && (m_burst > 0)) || ((ph == 2) && (m_debt > 0));
        case (m_op)
            0: if (need_v) m_op = 1;
            1: if (g) begin m_op = 2; m_step = 0; end
            2: if (m_step == CSR - 1) begin m_op = 3; m_step = 0; end else m_step++;
            3: if (m_step == RAS - 1) begin m_op = 4; m_step = 0; end else m_step++;
            default: if (m_step == RP - 1) begin m_op = 0; m_step = 0; end else m_step++;
        endcase
        if (ph == 2) begin
            if (tick_v && !done_v) m_debt = (m_debt < DMAX) ? m_debt + 1 : DMAX;
            else if (done_v && !tick_v && m_debt > 0) m_debt--;
            m_tmr = (m_tmr == INTERVAL - 1) ? 0 : m_tmr + 1;
        end
        if (ph == 0) begin
            if (m_settle == SETTLE - 1) m_phase = 1; else m_settle++;
        end else if (ph == 1 && done_v) begin
            m_burst--;
            if (m_burst == 0) m_phase = 2;
        end
    endtask

    task automatic finish_run();
        if (!summary_done) begin
            summary_done = 1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    endtask

    // Per-cycle comparison, grant policy and model advance, all at negedge.
    always @(negedge clk) begin
        bit e_req, e_ras, e_cas, e_rdy;
        cyc++;
        if (cyc <= RST_CYC) begin
            rst_n = 1'b0;
            bus_gnt = 1'b0;
            model_reset();
            if (cyc == RST_CYC) begin
                // R1: reset state
                check(ras_n === 1'b1, "R1 ras_n", ras_n, 1);
                check(cas_n === 1'b1, "R1 cas_n", cas_n, 1);
                check(bus_req === 1'b0, "R1 bus_req", bus_req, 0);
                check(ready === 1'b0, "R1 ready", ready, 0);
            end
        end else begin
            rst_n = 1'b1;
            e_req = (m_op != 0);
            e_ras = (m_op != 3);
            e_cas = !((m_op == 2) || ((m_op == 3) && (m_step < CHR)));
            e_rdy = (m_phase == 2);
            checks++;
            if (bus_req !== e_req || ras_n !== e_ras || cas_n !== e_cas || ready !== e_rdy) begin
                fails++;
                if (bus_req !== e_req) $display("FAIL R4 bus_req: actual %0d expected %0d (cycle %0d)", bus_req, e_req, cyc);
                if (ras_n !== e_ras)   $display("FAIL R3 ras_n: actual %0d expected %0d (cycle %0d)", ras_n, e_ras, cyc);
                if (cas_n !== e_cas)   $display("FAIL R3 cas_n: actual %0d expected %0d (cycle %0d)", cas_n, e_cas, cyc);
                if (ready !== e_rdy)   $display("FAIL R6 ready: actual %0d expected %0d (cycle %0d)", ready, e_rdy, cyc);
            end
            if (ready_seen && ready !== 1'b1) begin
                check(0, "R6 ready sticky", ready, 1);
            end
            if (ready === 1'b1) ready_seen = 1;
            if (bus_req === 1'b1 && first_req < 0) first_req = cyc - (RST_CYC + 1);
            if (prev_ras === 1'b1 && ras_n === 1'b0) begin
                falls++;
                if (!ready_seen) falls_pre_ready++;
            end
            prev_ras = ras_n;
            // grant policy from the model's request
            if (!e_req) begin
                bus_gnt = 1'b0;
                wait_cnt = 0;
            end else if (!bus_gnt) begin
                if (gnt_en && wait_cnt >= gnt_delay) bus_gnt = 1'b1;
                else wait_cnt++;
            end
            model_step(bus_gnt);
        end
    end

    task automatic wait_cycles(input int n);
        for (int i = 0; i < n; i++) @(posedge clk);
    endtask

    initial begin
        while (!ready_seen) @(posedge clk);
        // R2: first request exactly SETTLE+1 cycles after release
        check(first_req == SETTLE + 1, "R2 first request cycle", first_req, SETTLE + 1);
        // R5: init burst length
        check(falls_pre_ready == BURST, "R5 refreshes before ready", falls_pre_ready, BURST);

        // R7: steady rate with immediate grant
        falls = 0;
        wait_cycles(20 * INTERVAL);
        check(falls >= 19 && falls <= 20, "R7 rate, immediate grant", falls, 20);

        // R7: steady rate with delayed grant
        gnt_delay = 3;
        falls = 0;
        wait_cycles(10 * INTERVAL);
        check(falls >= 9 && falls <= 10, "R7 rate, grant delay 3", falls, 10);

        // R8: withhold grant, debt saturates, request persists
        gnt_en = 1'b0;
        wait_cycles(INTERVAL / 2);
        falls = 0;
        wait_cycles(15 * INTERVAL);
        check(falls == 0, "R4 no strobes without grant", falls, 0);
        check(bus_req === 1'b1, "R8 request held while owed", bus_req, 1);
        gnt_en = 1'b1;
        gnt_delay = 0;
        falls = 0;
        wait_cycles(100);
        check(falls >= DMAX && falls <= DMAX + 1, "R8 catch-up bounded by ceiling", falls, DMAX);

        // R9: backlog drained, rate back to one per interval
        wait_cycles(INTERVAL);
        falls = 0;
        wait_cycles(10 * INTERVAL);
        check(falls >= 9 && falls <= 10, "R9 rate after drain", falls, 10);
        check(ready === 1'b1, "R6 ready still high", ready, 1);

        finish_run();
    end

    initial begin
        #(CLK_P * 100000);
        fails++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

endmodule